// File: doc/BRIEF.md
# Peripheral Interrupt Routing Matrix

This block steers a bank of level-sensitive peripheral interrupt lines to two processor cores. Every source owns a small routing register whose two low bits say whether the source reaches core 0, core 1, both of them, or neither. Each core receives its own interrupt vector. Each bit of that vector is the live peripheral level gated by that core's enable bit for the source. No edge is captured and no level is held, so a source that drops is withdrawn from the cores at once.

Software programs the routes over a simple register bus. The bus has two windows. The routing window holds one halfword register per source. The core-identity window returns the number of the core that issues the access, so each core can build its own enable mask as one shifted left by its number. Every routing register clears on reset, so no interrupt reaches a core until software enables it.

Top module: `irq_route_matrix`

## Requirements
- R1: While reset is active and after it is released, every routing register is zero, and both core vectors stay zero whatever the peripheral inputs do.
- R2: Bit 0 of a source's routing register enables delivery to core 0. `cpu0_irq[n]` equals `src_irq[n]` AND that bit.
- R3: Bit 1 of a source's routing register enables delivery to core 1. `cpu1_irq[n]` equals `src_irq[n]` AND that bit.
- R4: With both bits set, the source drives both core vectors at the same time.
- R5: Writing zero to a routing register removes the source from both cores from the next cycle on.
- R6: In the routing window (`bus_win` = 1), the register of source n sits at byte offset 0x80 + 2*n. It is accessed as a 16-bit halfword, and a read returns the enable field in bits [1:0].
- R7: Bits [15:2] of every read return zero, and write data in those bits is ignored.
- R8: In the routing window, odd offsets, offsets below 0x80 and offsets above the last source's register read as zero. Writes to them change no route.
- R9: In the core-identity window (`bus_win` = 0), offset 0x4 returns the number of the accessing core (`bus_core`, 0 or 1) in bit 0. Every other offset in that window reads zero, and writes to that window change no route.
- R10: A write accepted on a rising clock edge affects the core vectors after that edge and not before. A change on a peripheral input reaches the core vectors in the same cycle, with no latching.
- R11: With `bus_en` low, a write request has no effect and the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | Window select: 0 = core identity, 1 = routing registers |
| bus_core | input | 1 | Number of the core issuing the access |
| bus_addr | input | ADDR_W (10) | Byte offset inside the selected window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational in the access cycle |
| src_irq | input | NUM_SRC (112) | Level-sensitive peripheral interrupt lines |
| cpu0_irq | output | NUM_SRC (112) | Interrupt vector delivered to core 0 |
| cpu1_irq | output | NUM_SRC (112) | Interrupt vector delivered to core 1 |

## Verification
The routing function is tried with every value of the enable field: core 0 only, core 1 only, both cores, neither core, and a value carrying reserved bits. Each of these is combined with the source line both raised and held low. These cases tell a swapped core bit apart from a missing gate. The sources chosen include the first, the last and several in the middle, so a wrong offset stride or an off-by-one in the index shows up as a readback or delivery on the wrong line. Directed cases place a write just before a clock edge and drop a source mid-cycle, which separates a route update that is registered too early or too late from an output that latches. Accesses to neighbouring unmapped offsets, to the other window and with the strobe low confirm that no route changes.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // Byte offset of the first routing halfword in the routing window.
    localparam int ROUTE_BASE  = 'h80;
    // Byte offset of the core-number register in the identity window.
    localparam int CORE_ID_OFF = 'h4;
    // Width of the register bus data path.
    localparam int DATA_W      = 16;

    typedef enum logic {
        WIN_CORE_ID = 1'b0,
        WIN_ROUTE   = 1'b1
    } bus_win_e;

    // Enable field of one routing register: bit 0 = core 0, bit 1 = core 1.
    typedef logic [1:0] route_field_t;

    function automatic route_field_t take_field(input logic [DATA_W-1:0] raw);
        return raw[1:0];
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 112,
    parameter int ADDR_W  = 10,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [ADDR_W-1:0] addr,
    input  bus_win_e          win,
    output logic              route_hit,
    output logic [IDX_W-1:0]  route_idx,
    output logic              core_id_hit
);

    localparam int LAST_OFF = ROUTE_BASE + 2 * (NUM_SRC - 1);

    logic [ADDR_W-1:0] rel_off;

    always_comb begin
        rel_off     = addr - ADDR_W'(ROUTE_BASE);
        route_hit   = (win == WIN_ROUTE)
                    && (addr >= ADDR_W'(ROUTE_BASE))
                    && (addr <= ADDR_W'(LAST_OFF))
                    && !addr[0];
        route_idx   = rel_off[IDX_W:1];
        core_id_hit = (win == WIN_CORE_ID) && (addr == ADDR_W'(CORE_ID_OFF));
    end

endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 112,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  route_field_t       wr_field,
    input  logic [IDX_W-1:0]   rd_idx,
    output route_field_t       rd_field,
    output logic [NUM_SRC-1:0] en_core0,
    output logic [NUM_SRC-1:0] en_core1
);

    typedef struct packed {
        logic [NUM_SRC-1:0] en0;
        logic [NUM_SRC-1:0] en1;
    } route_state_t;

    route_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en0[wr_idx] = wr_field[0];
            st_d.en1[wr_idx] = wr_field[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_field = {st_q.en1[rd_idx], st_q.en0[rd_idx]};
    assign en_core0 = st_q.en0;
    assign en_core1 = st_q.en1;

endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout #(
    parameter int NUM_SRC = 112
) (
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic [NUM_SRC-1:0] en_core0,
    input  logic [NUM_SRC-1:0] en_core1,
    output logic [NUM_SRC-1:0] out_core0,
    output logic [NUM_SRC-1:0] out_core1
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign out_core0[g] = src_lvl[g] & en_core0[g];
        assign out_core1[g] = src_lvl[g] & en_core1[g];
    end

endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 112,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic               bus_win,
    input  logic               bus_core,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_irq,
    output logic [NUM_SRC-1:0] cpu0_irq,
    output logic [NUM_SRC-1:0] cpu1_irq
);

    localparam int IDX_W = $clog2(NUM_SRC);

    logic               route_hit;
    logic               core_id_hit;
    logic [IDX_W-1:0]   route_idx;
    route_field_t       rd_field;
    logic [NUM_SRC-1:0] en_core0;
    logic [NUM_SRC-1:0] en_core1;
    logic               wr_route;

    irq_route_decode #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_decode (
        .addr        (bus_addr),
        .win         (bus_win_e'(bus_win)),
        .route_hit   (route_hit),
        .route_idx   (route_idx),
        .core_id_hit (core_id_hit)
    );

    assign wr_route = bus_en && bus_we && route_hit;

    irq_route_regs #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_route),
        .wr_idx   (route_idx),
        .wr_field (take_field(bus_wdata)),
        .rd_idx   (route_idx),
        .rd_field (rd_field),
        .en_core0 (en_core0),
        .en_core1 (en_core1)
    );

    irq_route_fanout #(
        .NUM_SRC (NUM_SRC)
    ) u_fanout (
        .src_lvl   (src_irq),
        .en_core0  (en_core0),
        .en_core1  (en_core1),
        .out_core0 (cpu0_irq),
        .out_core1 (cpu1_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (route_hit) begin
                bus_rdata[1:0] = rd_field;
            end else if (core_id_hit) begin
                bus_rdata[0] = bus_core;
            end
        end
    end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int NUM_SRC = 112,
    parameter int ADDR_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               bus_we,
    input logic               bus_win,
    input logic               bus_core,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [15:0]        bus_rdata,
    input logic [NUM_SRC-1:0] src_irq,
    input logic [NUM_SRC-1:0] cpu0_irq,
    input logic [NUM_SRC-1:0] cpu1_irq
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (cpu0_irq == '0 && cpu1_irq == '0));

    p_core0_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu0_irq & ~src_irq) == '0);

    p_core1_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu1_irq & ~src_irq) == '0);

    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:2] == '0);

    p_core_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !bus_win && bus_addr == ADDR_W'(4))
        |-> (bus_rdata == {15'd0, bus_core}));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!(bus_en && bus_we)) && $stable(src_irq))
        |-> ($stable(cpu0_irq) && $stable(cpu1_irq)));

    p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> (bus_rdata == '0));

endmodule

bind irq_route_matrix irq_route_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_win   (bus_win),
    .bus_core  (bus_core),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .src_irq   (src_irq),
    .cpu0_irq  (cpu0_irq),
    .cpu1_irq  (cpu1_irq)
);

// File: tb/sim_irq_route_matrix.sv
`timescale 1ns/1ps
module sim_irq_route_matrix;

    localparam int NUM_SRC = 112;
    localparam int ADDR_W  = 10;
    localparam int LIMIT   = 200000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_en = 1'b0;
    logic               bus_we = 1'b0;
    logic               bus_win = 1'b0;
    logic               bus_core = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [15:0]        bus_wdata = '0;
    logic [15:0]        bus_rdata;
    logic [NUM_SRC-1:0] src_irq = '0;
    logic [NUM_SRC-1:0] cpu0_irq;
    logic [NUM_SRC-1:0] cpu1_irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    irq_route_matrix #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_win   (bus_win),
        .bus_core  (bus_core),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_irq   (src_irq),
        .cpu0_irq  (cpu0_irq),
        .cpu1_irq  (cpu1_irq)
    );

    typedef struct packed {
        logic [6:0]  idx;
        logic [15:0] wval;
        logic        lvl;
        logic        e0;
        logic        e1;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{7'd0,   16'h0001, 1'b1, 1'b1, 1'b0},
        '{7'd5,   16'h0002, 1'b1, 1'b0, 1'b1},
        '{7'd111, 16'h0003, 1'b1, 1'b1, 1'b1},
        '{7'd40,  16'h0003, 1'b0, 1'b0, 1'b0},
        '{7'd64,  16'h0000, 1'b1, 1'b0, 1'b0},
        '{7'd1,   16'h0007, 1'b1, 1'b1, 1'b1},
        '{7'd110, 16'hFFFE, 1'b1, 1'b0, 1'b1},
        '{7'd77,  16'h0001, 1'b0, 1'b0, 1'b0}
    };

    function automatic logic [ADDR_W-1:0] src_off(input int n);
        return ADDR_W'('h80 + 2 * n);
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic win, input logic [ADDR_W-1:0] a,
                             input logic [15:0] d, input logic core);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_win = win;
        bus_addr = a; bus_wdata = d; bus_core = core;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic win, input logic [ADDR_W-1:0] a,
                            input logic core, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_win = win;
        bus_addr = a; bus_core = core;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    initial begin
        #(8.0 * LIMIT);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [NUM_SRC-1:0] one;

        // R1: during reset, outputs stay zero with every source raised
        src_irq = '1;
        repeat (3) @(negedge clk);
        check("R1 cpu0 in reset", 128'(cpu0_irq), 128'd0);
        check("R1 cpu1 in reset", 128'(cpu1_irq), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cpu0 after reset", 128'(cpu0_irq), 128'd0);
        check("R1 cpu1 after reset", 128'(cpu1_irq), 128'd0);
        bus_read(1'b1, src_off(17), 1'b0, rd);
        check("R1 route readback zero", 128'(rd), 128'd0);

        // R8: unmapped routing offsets take no write and read zero
        bus_write(1'b1, ADDR_W'('h7E), 16'h0003, 1'b0);
        bus_write(1'b1, ADDR_W'('h81), 16'h0003, 1'b0);
        bus_write(1'b1, ADDR_W'('h160), 16'h0003, 1'b0);
        @(negedge clk);
        check("R8 cpu0 after unmapped writes", 128'(cpu0_irq), 128'd0);
        check("R8 cpu1 after unmapped writes", 128'(cpu1_irq), 128'd0);
        bus_read(1'b1, ADDR_W'('h7E), 1'b0, rd);
        check("R8 read below base", 128'(rd), 128'd0);
        bus_read(1'b1, ADDR_W'('h81), 1'b0, rd);
        check("R8 read odd offset", 128'(rd), 128'd0);
        bus_read(1'b1, ADDR_W'('h160), 1'b0, rd);
        check("R8 read past last", 128'(rd), 128'd0);

        // R9: core-identity window; writes there leave routes alone
        bus_write(1'b0, src_off(0), 16'h0003, 1'b1);
        bus_write(1'b0, ADDR_W'('h4), 16'h0003, 1'b1);
        @(negedge clk);
        check("R9 cpu0 after identity-window writes", 128'(cpu0_irq), 128'd0);
        check("R9 cpu1 after identity-window writes", 128'(cpu1_irq), 128'd0);
        bus_read(1'b0, ADDR_W'('h4), 1'b0, rd);
        check("R9 core number 0", 128'(rd), 128'd0);
        bus_read(1'b0, ADDR_W'('h4), 1'b1, rd);
        check("R9 core number 1", 128'(rd), 128'd1);
        bus_read(1'b0, ADDR_W'('h0), 1'b1, rd);
        check("R9 other identity offset", 128'(rd), 128'd0);

        // R11: write request with strobe low does nothing
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b1; bus_win = 1'b1;
        bus_addr = src_off(3); bus_wdata = 16'h0003;
        #1;
        check("R11 idle read data", 128'(bus_rdata), 128'd0);
        @(negedge clk);
        bus_we = 1'b0;
        check("R11 cpu0 unchanged", 128'(cpu0_irq), 128'd0);
        check("R11 cpu1 unchanged", 128'(cpu1_irq), 128'd0);

        // R2 R3 R4 R6 R7: vector table
        for (int i = 0; i < NV; i++) begin
            src_irq = '0;
            bus_write(1'b1, src_off(int'(VECS[i].idx)), VECS[i].wval, 1'b0);
            one = '0;
            one[VECS[i].idx] = VECS[i].lvl;
            src_irq = one;
            #1;
            check($sformatf("R2 vec%0d cpu0", i), 128'(cpu0_irq),
                  128'(VECS[i].e0) << VECS[i].idx);
            check($sformatf("R3 R4 vec%0d cpu1", i), 128'(cpu1_irq),
                  128'(VECS[i].e1) << VECS[i].idx);
            bus_read(1'b1, src_off(int'(VECS[i].idx)), 1'b1, rd);
            check($sformatf("R6 R7 vec%0d readback", i), 128'(rd),
                  128'(VECS[i].wval & 16'h0003));
        end
        src_irq = '0;

        // R5: zero write removes source from both cores
        bus_write(1'b1, src_off(9), 16'h0003, 1'b0);
        src_irq = '0; src_irq[9] = 1'b1;
        #1;
        check("R5 both before clear", 128'({cpu1_irq[9], cpu0_irq[9]}), 128'd3);
        bus_write(1'b1, src_off(9), 16'h0000, 1'b1);
        check("R5 cpu0 after clear", 128'(cpu0_irq), 128'd0);
        check("R5 cpu1 after clear", 128'(cpu1_irq), 128'd0);

        // R10: write lands only after the accepting edge; level has no latch
        src_irq = '0; src_irq[20] = 1'b1;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_win = 1'b1;
        bus_addr = src_off(20); bus_wdata = 16'h0001;
        #1;
        check("R10 before accepting edge", 128'(cpu0_irq[20]), 128'd0);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        check("R10 after accepting edge", 128'(cpu0_irq[20]), 128'd1);
        src_irq[20] = 1'b0;
        #1;
        check("R10 source drop same cycle", 128'(cpu0_irq[20]), 128'd0);
        src_irq[20] = 1'b1;
        #1;
        check("R10 source rise same cycle", 128'(cpu0_irq[20]), 128'd1);
        src_irq = '0;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule